// File: doc/BRIEF.md
# Boundary Scan Register Ring

This block places one test cell beside every chip pin and threads all of the cells into a single serial path. The path runs from a test data input to a test data output. Each cell holds a shift stage, an update stage and a selector. The shift stage captures or shifts on the rising test-clock edge. The update stage loads from the shift stage on the falling edge. The selector picks either the functional signal or the value held in the update stage. Output-pin cells sit between the core's outputs and the pads. Input-pin cells sit between the pads and the core's inputs.

A test access port controller, which is not part of this block, drives five control lines: capture, shift, update and two mode flags. With the external-test flag set, the pads show the update stages and the core is cut off from them. This lets a board tester drive a pattern onto the board traces and read back what the input pins received. With the internal-test flag set, the update stages drive the core's inputs and a capture records the core's outputs. With both flags clear, every selector passes its functional signal, so the ring cannot be seen in normal operation. A pure loopback check shifts a pattern through with no capture and no update, and the pattern returns after as many clocks as there are cells.

Top module: `bsr_ring`

## Requirements
- R1: The ring has N_OUT + N_IN cells. On each rising clock edge with the shift control high, every cell takes the value of its neighbour on the input side, and the cell farthest from the output takes tdi. tdo always shows cell 0, so a bit on tdi appears on tdo after N_OUT + N_IN shifts.
- R2: Cell positions 0 to N_IN-1 belong to input pins, with pad_in[i] at position i. Positions N_IN to N_IN+N_OUT-1 belong to output pins, with pad_out[j] and core_out[j] at position N_IN+j. Position 0 is the one nearest tdo.
- R3: On a rising edge with capture high and shift low, input cells load pad_in and output cells load core_out. The captured values then come out on tdo in position order.
- R4: When update is high and shift is low, every update stage loads its cell's shift stage on the falling clock edge. Otherwise the update stages hold their values.
- R5: While mode_extest is high, pad_out equals the update stages of the output cells and core_out has no effect on it. While mode_extest is low, pad_out equals core_out.
- R6: While mode_intest is high, core_in equals the update stages of the input cells and pad_in has no effect on it. While mode_intest is low, core_in equals pad_in.
- R7: Shifting with capture and update both low leaves every update stage, and therefore pad_out in external-test mode, unchanged. Every pattern comes back on tdo delayed by the ring length.
- R8: While rst is high at a rising edge, all shift stages and all update stages become 0.
- R9: When shift and capture are both high, the cells shift and do not capture. When shift and update are both high, the update stages do not load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; shift and capture on the rising edge, update on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| tdi | input | 1 | Serial test data into the far end of the ring |
| tdo | output | 1 | Serial test data out of cell 0 |
| capture_en | input | 1 | Load the cells from their functional inputs |
| shift_en | input | 1 | Move the ring one position toward tdo |
| update_en | input | 1 | Copy the shift stages into the update stages on the falling edge |
| mode_extest | input | 1 | Pads driven from the output update stages |
| mode_intest | input | 1 | Core inputs driven from the input update stages |
| core_out | input | N_OUT | Functional outputs of the core |
| pad_out | output | N_OUT | Values toward the output pads |
| pad_in | input | N_IN | Values arriving from the input pads |
| core_in | output | N_IN | Values toward the core inputs |

## Verification
tdo reflects a shift or capture one rising edge after the control is applied. A pad or core-input value loaded by an update appears half a period into that same cycle, at the falling edge. The selector outputs follow core_out, pad_in and the mode flags within the same cycle. The bench changes its inputs one time unit after a rising edge and reads every output just after the following rising edge, by which time both the falling-edge update and the rising-edge shift have happened. The expected values come from a bench model of the ring and the update stages, which advances one step for each control cycle the bench applies.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    // kind of pin a cell sits beside
    typedef enum logic {
        CELL_IN  = 1'b0,
        CELL_OUT = 1'b1
    } cell_kind_e;

    // decoded per-cycle controls shared by every cell
    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
        logic extest;
        logic intest;
    } bsr_ctl_t;

    function automatic int unsigned ring_len(int unsigned n_out, int unsigned n_in);
        return n_out + n_in;
    endfunction

endpackage

// File: rtl/bsr_ctl.sv
module bsr_ctl
    import bsr_pkg::*;
(
    input  logic     capture_en,
    input  logic     shift_en,
    input  logic     update_en,
    input  logic     mode_extest,
    input  logic     mode_intest,
    output bsr_ctl_t ctl
);

    // shift has priority over capture and update
    always_comb begin
        ctl.shift   = shift_en;
        ctl.capture = capture_en & ~shift_en;
        ctl.update  = update_en & ~shift_en;
        ctl.extest  = mode_extest;
        ctl.intest  = mode_intest;
    end

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
    import bsr_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_OUT
) (
    input  logic     clk,
    input  logic     rst,
    input  bsr_ctl_t ctl,
    input  logic     scan_in,
    input  logic     func_in,
    output logic     scan_q,
    output logic     hold_q,
    output logic     func_out
);

    logic test_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_q <= 1'b0;
        end else if (ctl.shift) begin
            scan_q <= scan_in;
        end else if (ctl.capture) begin
            scan_q <= func_in;
        end
    end

    // update stage moves on the falling edge, away from shifting
    always_ff @(negedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else if (ctl.update) begin
            hold_q <= scan_q;
        end
    end

    generate
        if (KIND == CELL_OUT) begin : g_out
            assign test_sel = ctl.extest;
        end else begin : g_in
            assign test_sel = ctl.intest;
        end
    endgenerate

    assign func_out = test_sel ? hold_q : func_in;

endmodule

// File: rtl/bsr_ring.sv
module bsr_ring
    import bsr_pkg::*;
#(
    parameter int unsigned N_OUT = 6,
    parameter int unsigned N_IN  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tdi,
    output logic             tdo,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic             mode_extest,
    input  logic             mode_intest,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] pad_out,
    input  logic [N_IN-1:0]  pad_in,
    output logic [N_IN-1:0]  core_in
);

    localparam int unsigned L = ring_len(N_OUT, N_IN);

    bsr_ctl_t       ctl;
    logic [L-1:0]   chain_q;
    logic [L-1:0]   chain_next;
    logic [L-1:0]   latch_q;

    bsr_ctl u_ctl (
        .capture_en  (capture_en),
        .shift_en    (shift_en),
        .update_en   (update_en),
        .mode_extest (mode_extest),
        .mode_intest (mode_intest),
        .ctl         (ctl)
    );

    // each cell takes its neighbour on the tdi side
    assign chain_next = {tdi, chain_q[L-1:1]};

    genvar gi;
    generate
        for (gi = 0; gi < N_IN; gi++) begin : g_in_cell
            bsr_cell #(.KIND(CELL_IN)) u_cell (
                .clk      (clk),
                .rst      (rst),
                .ctl      (ctl),
                .scan_in  (chain_next[gi]),
                .func_in  (pad_in[gi]),
                .scan_q   (chain_q[gi]),
                .hold_q   (latch_q[gi]),
                .func_out (core_in[gi])
            );
        end
        for (gi = 0; gi < N_OUT; gi++) begin : g_out_cell
            bsr_cell #(.KIND(CELL_OUT)) u_cell (
                .clk      (clk),
                .rst      (rst),
                .ctl      (ctl),
                .scan_in  (chain_next[N_IN+gi]),
                .func_in  (core_out[gi]),
                .scan_q   (chain_q[N_IN+gi]),
                .hold_q   (latch_q[N_IN+gi]),
                .func_out (pad_out[gi])
            );
        end
    endgenerate

    assign tdo = chain_q[0];

endmodule

// File: rtl/bsr_ring_chk.sv
module bsr_ring_chk #(
    parameter int unsigned N_OUT = 6,
    parameter int unsigned N_IN  = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tdi,
    input logic                  capture_en,
    input logic                  shift_en,
    input logic                  update_en,
    input logic                  mode_extest,
    input logic                  mode_intest,
    input logic [N_OUT-1:0]      core_out,
    input logic [N_OUT-1:0]      pad_out,
    input logic [N_IN-1:0]       pad_in,
    input logic [N_IN-1:0]       core_in,
    input logic [N_OUT+N_IN-1:0] chain_q,
    input logic [N_OUT+N_IN-1:0] latch_q
);

    localparam int unsigned L = N_OUT + N_IN;

    // R1
    shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> chain_q[L-1] == $past(tdi));

    // R3
    capture_pads_chk: assert property (@(posedge clk) disable iff (rst)
        (capture_en && !shift_en) |=> chain_q[N_IN-1:0] == $past(pad_in));

    // R3
    capture_core_chk: assert property (@(posedge clk) disable iff (rst)
        (capture_en && !shift_en) |=> chain_q[L-1:N_IN] == $past(core_out));

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!update_en || shift_en) |-> $stable(latch_q));

    // R4
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        (update_en && !shift_en) |-> latch_q == chain_q);

    // R5
    pad_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_extest |-> pad_out == core_out);

    // R6
    core_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_intest |-> core_in == pad_in);

endmodule

bind bsr_ring bsr_ring_chk #(.N_OUT(N_OUT), .N_IN(N_IN)) u_chk (.*);

// File: tb/bsr_ring_tb.sv
module bsr_ring_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_OUT = 6;
    localparam int N_IN  = 5;
    localparam int L     = N_OUT + N_IN;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tdi = 1'b0;
    logic             tdo;
    logic             capture_en = 1'b0;
    logic             shift_en = 1'b0;
    logic             update_en = 1'b0;
    logic             mode_extest = 1'b0;
    logic             mode_intest = 1'b0;
    logic [N_OUT-1:0] core_out = '0;
    logic [N_OUT-1:0] pad_out;
    logic [N_IN-1:0]  pad_in = '0;
    logic [N_IN-1:0]  core_in;

    // bench model of the ring and of the update stages
    logic [L-1:0] m_sr  = '0;
    logic [L-1:0] m_lat = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    bsr_ring #(.N_OUT(N_OUT), .N_IN(N_IN)) u_dut (
        .clk(clk), .rst(rst), .tdi(tdi), .tdo(tdo),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .mode_extest(mode_extest), .mode_intest(mode_intest),
        .core_out(core_out), .pad_out(pad_out),
        .pad_in(pad_in), .core_in(core_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [L-1:0] after_shift(logic [L-1:0] s, logic b);
        return {b, s[L-1:1]};
    endfunction

    function automatic logic [L-1:0] after_capture(logic [N_OUT-1:0] co, logic [N_IN-1:0] pi);
        return {co, pi};
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic shift_bit(logic b, string tag);
        shift_en = 1'b1;
        tdi = b;
        tick();
        m_sr = after_shift(m_sr, b);
        shift_en = 1'b0;
        check(tdo === m_sr[0], tag, 32'(tdo), 32'(m_sr[0]));
    endtask

    task automatic do_update();
        update_en = 1'b1;
        tick();
        m_lat = m_sr;
        update_en = 1'b0;
    endtask

    task automatic do_capture();
        capture_en = 1'b1;
        tick();
        m_sr = after_capture(core_out, pad_in);
        capture_en = 1'b0;
        check(tdo === m_sr[0], "R3 capture tdo", 32'(tdo), 32'(m_sr[0]));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        pad_in   = N_IN'($urandom);
        core_out = N_OUT'($urandom);
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R8 reset state
        check(tdo === 1'b0, "R8 tdo after reset", 32'(tdo), 0);
        mode_extest = 1'b1;
        mode_intest = 1'b1;
        #1;
        check(pad_out === '0, "R8 output latches cleared", 32'(pad_out), 0);
        check(core_in === '0, "R8 input latches cleared", 32'(core_in), 0);
        mode_extest = 1'b0;
        mode_intest = 1'b0;
        #1;
        // R5 R6 functional pass-through
        check(pad_out === core_out, "R5 pass-through", 32'(pad_out), 32'(core_out));
        check(core_in === pad_in, "R6 pass-through", 32'(core_in), 32'(pad_in));

        // R1 R7 loopback: pattern returns after L shifts, latches untouched
        mode_extest = 1'b1;
        for (int k = 0; k < 3 * L; k++) begin
            shift_bit(1'($urandom), "R1 loopback tdo");
            core_out = N_OUT'($urandom);
            #1;
            check(pad_out === m_lat[L-1:N_IN], "R7 pads hold during shift",
                  32'(pad_out), 32'(m_lat[L-1:N_IN]));
        end

        // R4 R5 R2 external test
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < L; k++) shift_bit(1'($urandom), "R1 extest shift");
            do_update();
            for (int c = 0; c < 3; c++) begin
                core_out = N_OUT'($urandom);
                #1;
                check(pad_out === m_lat[L-1:N_IN], "R5 extest pads from latches",
                      32'(pad_out), 32'(m_lat[L-1:N_IN]));
            end
        end

        // R9 update suppressed while shifting
        update_en = 1'b1;
        shift_bit(~m_sr[L-1], "R9 shift with update");
        update_en = 1'b0;
        #1;
        check(pad_out === m_lat[L-1:N_IN], "R9 update blocked by shift",
              32'(pad_out), 32'(m_lat[L-1:N_IN]));

        // R3 R2 capture of pads and core outputs, then read out
        for (int r = 0; r < 4; r++) begin
            pad_in   = N_IN'($urandom);
            core_out = N_OUT'($urandom);
            do_capture();
            for (int k = 0; k < L; k++) shift_bit(1'($urandom), "R2 captured bit order");
        end

        // R9 capture and shift together: shift wins
        pad_in = N_IN'($urandom);
        capture_en = 1'b1;
        for (int k = 0; k < L; k++) shift_bit(1'($urandom), "R9 shift over capture");
        capture_en = 1'b0;

        // R6 internal test
        mode_extest = 1'b0;
        mode_intest = 1'b1;
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < L; k++) shift_bit(1'($urandom), "R1 intest shift");
            do_update();
            for (int c = 0; c < 3; c++) begin
                pad_in   = N_IN'($urandom);
                core_out = N_OUT'($urandom);
                #1;
                check(core_in === m_lat[N_IN-1:0], "R6 intest core from latches",
                      32'(core_in), 32'(m_lat[N_IN-1:0]));
                check(pad_out === core_out, "R5 pads functional in intest",
                      32'(pad_out), 32'(core_out));
            end
            do_capture();
            for (int k = 0; k < L; k++) shift_bit(1'($urandom), "R3 intest response out");
        end

        // R5 R6 normal mode after test modes
        mode_intest = 1'b0;
        for (int c = 0; c < 8; c++) begin
            pad_in   = N_IN'($urandom);
            core_out = N_OUT'($urandom);
            #1;
            check(pad_out === core_out, "R5 normal pads", 32'(pad_out), 32'(core_out));
            check(core_in === pad_in, "R6 normal core", 32'(core_in), 32'(pad_in));
        end

        tick();
        finish_run();
    end

endmodule